// File: doc/BRIEF.md
# Voltage-Frequency Performance Level Controller

This block turns a software performance request, given as a percentage from 0 to 100, into one of eight operating points. Each operating point pairs a supply voltage code with a clock-select code. The block then moves the processor's supply and clock to that point in a safe order, so that the clock never runs faster than the present supply voltage can support. Software programs the request and an upper performance cap through an APB slave. Through the same slave it reads back the target and current operating-point indices and a transition-in-progress flag.

An external supply receives the voltage code and signals readiness on `v_ready`. When the level rises, the block asks for the higher voltage first. It moves the clock up only after it sees `v_ready` high. When the level falls, the block lowers the clock first and then the voltage, and it does not wait for the supply. If a new request arrives during a transition, it becomes the new target and is acted on once the running transition has finished.

Two free-running counters let software estimate load. One counts every clock cycle. The other counts the cycles in which `cpu_active` is high.

Top module: `perf_level_ctrl`

## Requirements
- R1: After reset the voltage code is VMIN (default 4) and the clock select is 0. The current and target indices are 0, the status register reads 0, and the cap register reads 100.
- R2: The request register (offset 0x00) and the cap register (offset 0x04) store bits [6:0] of an APB write. Each reads back the stored value in bits [6:0], with zeros above.
- R3: Entry i (0..7) has the threshold floor(i*100/8), that is 0,12,25,37,50,62,75,87. Its voltage code is VMIN+i and its clock select is i. The target index is the highest entry whose threshold does not exceed the clamped percentage. A request above 100 is treated as 100.
- R4: The clamped percentage is the smaller of the request, 100 and the cap register. A cap of 40 therefore limits the target to index 3.
- R5: On an increase the voltage code changes to the new entry first. The clock select and the current index hold while `v_ready` is low. They take the new entry on the first rising clock edge at which `v_ready` is high.
- R6: On a decrease the clock select drops to the new entry one cycle after the block sees the new target. The voltage code and the current index follow on the next cycle, whatever the level of `v_ready`.
- R7: A request written during a transition updates the target at once. That request is carried out only after the running transition ends.
- R8: The status register (offset 0x08) holds the busy flag in bit 0, the current index in bits [6:4] and the target index in bits [10:8]. Busy reads 1 while a transition runs or the current index differs from the target, and 0 otherwise.
- R9: The register at offset 0x0C counts all cycles. The register at offset 0x10 counts the cycles in which `cpu_active` is high. Any write to 0x0C clears both counters.
- R10: The voltage code is never below VMIN plus the clock select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 5 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| v_ready | input | 1 | Supply reports that the requested voltage is reached |
| cpu_active | input | 1 | Processor busy indication for the load counter |
| vcode | output | 4 | Voltage code requested from the supply |
| clk_sel | output | 3 | Clock-select code for the clock generator |

## Verification
The mapping is exercised with requests at the threshold edges (11 against 12), a mid-range value, the full value and an out-of-range value above 100. These show that the search picks the highest matching entry and that clamping applies. Raises and drops are run with `v_ready` held low, which separates the wait-for-ready order from the clock-first order. A cap lower than the request checks that the cap bounds the target. A request written in the middle of a raise checks that the pending target is taken up afterwards. The counters are checked with a known count of active cycles after a clear.

// File: rtl/plc_pkg.sv
package plc_pkg;
  localparam int NLVL    = 8;
  localparam int LVL_W   = $clog2(NLVL);
  localparam int VC_W    = 4;
  localparam int CS_W    = 3;
  localparam int PCT_W   = 7;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int CNT_W   = 32;
  localparam int PCT_MAX = 100;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RAISE = 2'd1,
    ST_LOWER = 2'd2
  } seq_st_t;

  function automatic logic [PCT_W-1:0] lvl_thresh(input int unsigned i);
    return PCT_W'((i * PCT_MAX) / NLVL);
  endfunction
endpackage

// File: rtl/plc_level_map.sv
module plc_level_map
  import plc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PCT_W-1:0] req_pct,
  input  logic [PCT_W-1:0] cap_pct,
  output logic [LVL_W-1:0] tgt_idx
);
  logic [PCT_W-1:0] lim_req;
  logic [PCT_W-1:0] lim;
  logic [NLVL-1:0]  hit;

  always_comb begin
    lim_req = (req_pct > PCT_W'(PCT_MAX)) ? PCT_W'(PCT_MAX) : req_pct;
    lim     = (cap_pct < lim_req) ? cap_pct : lim_req;
  end

  for (genvar g = 0; g < NLVL; g++) begin : g_cmp
    assign hit[g] = (lvl_thresh(g) <= lim);
  end

  always_comb begin
    tgt_idx = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (hit[i]) tgt_idx = LVL_W'(i);
    end
  end

  AST_TGT_UNDER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_thresh(tgt_idx) <= cap_pct); // R4
endmodule

// File: rtl/plc_seq.sv
module plc_seq
  import plc_pkg::*;
#(
  parameter int VMIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tgt_idx,
  input  logic             v_ready,
  output logic [LVL_W-1:0] cur_idx,
  output logic [VC_W-1:0]  vcode,
  output logic [CS_W-1:0]  clk_sel,
  output logic             busy
);
  seq_st_t          st_q, st_n;
  logic [LVL_W-1:0] cur_q, cur_n, step_q, step_n;
  logic [VC_W-1:0]  vc_q, vc_n;
  logic [CS_W-1:0]  cs_q, cs_n;

  always_comb begin
    st_n   = st_q;
    cur_n  = cur_q;
    step_n = step_q;
    vc_n   = vc_q;
    cs_n   = cs_q;
    unique case (st_q)
      ST_IDLE: begin
        if (tgt_idx > cur_q) begin
          vc_n   = VC_W'(VMIN) + VC_W'(tgt_idx);
          step_n = tgt_idx;
          st_n   = ST_RAISE;
        end else if (tgt_idx < cur_q) begin
          cs_n   = CS_W'(tgt_idx);
          step_n = tgt_idx;
          st_n   = ST_LOWER;
        end
      end
      ST_RAISE: begin
        if (v_ready) begin
          cs_n  = CS_W'(step_q);
          cur_n = step_q;
          st_n  = ST_IDLE;
        end
      end
      ST_LOWER: begin
        vc_n  = VC_W'(VMIN) + VC_W'(step_q);
        cur_n = step_q;
        st_n  = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      step_q <= '0;
      vc_q   <= VC_W'(VMIN);
      cs_q   <= '0;
    end else begin
      st_q   <= st_n;
      cur_q  <= cur_n;
      step_q <= step_n;
      vc_q   <= vc_n;
      cs_q   <= cs_n;
    end
  end

  assign cur_idx = cur_q;
  assign vcode   = vc_q;
  assign clk_sel = cs_q;
  assign busy    = (st_q != ST_IDLE) || (cur_q != tgt_idx);

  AST_CLK_UP_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q > $past(cs_q)) |-> $past(v_ready)); // R5
  AST_VOLT_COVERS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    vc_q >= VC_W'(VMIN) + VC_W'(cs_q)); // R10
  AST_LOWER_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOWER) |=> (st_q == ST_IDLE)); // R6
  AST_SETTLED_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (vc_q == VC_W'(VMIN) + VC_W'(cur_q)) && (cs_q == CS_W'(cur_q))); // R8
endmodule

// File: rtl/plc_load_cnt.sv
module plc_load_cnt
  import plc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             active,
  output logic [CNT_W-1:0] total_cnt,
  output logic [CNT_W-1:0] busy_cnt
);
  logic [CNT_W-1:0] tot_n, bsy_n;

  always_comb begin
    tot_n = clr ? '0 : total_cnt + 1'b1;
    bsy_n = clr ? '0 : (active ? busy_cnt + 1'b1 : busy_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_cnt <= '0;
      busy_cnt  <= '0;
    end else begin
      total_cnt <= tot_n;
      busy_cnt  <= bsy_n;
    end
  end

  AST_BUSY_LE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= total_cnt); // R9
endmodule

// File: rtl/plc_apb_regs.sv
module plc_apb_regs
  import plc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              busy,
  input  logic [LVL_W-1:0]  cur_idx,
  input  logic [LVL_W-1:0]  tgt_idx,
  input  logic [CNT_W-1:0]  total_cnt,
  input  logic [CNT_W-1:0]  busy_cnt,
  output logic [PCT_W-1:0]  req_pct,
  output logic [PCT_W-1:0]  cap_pct,
  output logic              cnt_clr
);
  localparam logic [2:0] A_REQ = 3'd0, A_CAP = 3'd1, A_STAT = 3'd2,
                         A_TOT = 3'd3, A_BSY = 3'd4;

  logic       wr_en;
  logic [2:0] word;
  logic       req_we, cap_we;

  assign word    = paddr[4:2];
  assign wr_en   = psel && penable && pwrite;
  assign req_we  = wr_en && (word == A_REQ);
  assign cap_we  = wr_en && (word == A_CAP);
  assign cnt_clr = wr_en && (word == A_TOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_pct <= '0;
      cap_pct <= PCT_W'(PCT_MAX);
    end else begin
      if (req_we) req_pct <= pwdata[PCT_W-1:0];
      if (cap_we) cap_pct <= pwdata[PCT_W-1:0];
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      unique case (word)
        A_REQ:   prdata[PCT_W-1:0] = req_pct;
        A_CAP:   prdata[PCT_W-1:0] = cap_pct;
        A_STAT: begin
          prdata[0]         = busy;
          prdata[4+:LVL_W]  = cur_idx;
          prdata[8+:LVL_W]  = tgt_idx;
        end
        A_TOT:   prdata = DATA_W'(total_cnt);
        A_BSY:   prdata = DATA_W'(busy_cnt);
        default: prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/perf_level_ctrl.sv
module perf_level_ctrl
  import plc_pkg::*;
#(
  parameter int VMIN = 4
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              v_ready,
  input  logic              cpu_active,
  output logic [VC_W-1:0]   vcode,
  output logic [CS_W-1:0]   clk_sel
);
  logic [PCT_W-1:0] req_pct, cap_pct;
  logic [LVL_W-1:0] tgt_idx, cur_idx;
  logic             busy, cnt_clr;
  logic [CNT_W-1:0] total_cnt, busy_cnt;

  plc_apb_regs u_regs (
    .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .busy(busy), .cur_idx(cur_idx), .tgt_idx(tgt_idx),
    .total_cnt(total_cnt), .busy_cnt(busy_cnt),
    .req_pct(req_pct), .cap_pct(cap_pct), .cnt_clr(cnt_clr)
  );

  plc_level_map u_map (
    .clk(pclk), .rst_n(presetn), .req_pct(req_pct), .cap_pct(cap_pct),
    .tgt_idx(tgt_idx)
  );

  plc_seq #(.VMIN(VMIN)) u_seq (
    .clk(pclk), .rst_n(presetn), .tgt_idx(tgt_idx), .v_ready(v_ready),
    .cur_idx(cur_idx), .vcode(vcode), .clk_sel(clk_sel), .busy(busy)
  );

  plc_load_cnt u_cnt (
    .clk(pclk), .rst_n(presetn), .clr(cnt_clr), .active(cpu_active),
    .total_cnt(total_cnt), .busy_cnt(busy_cnt)
  );
endmodule

// File: tb/sim_perf_level_ctrl.sv
module sim_perf_level_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        pclk = 1'b0;
  logic        presetn;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        v_ready = 1'b0, cpu_active = 1'b0;
  logic [3:0]  vcode;
  logic [2:0]  clk_sel;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } sb_item_t;
  sb_item_t sb[$];

  always #(CLK_PERIOD/2) pclk = ~pclk;

  perf_level_ctrl u0 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .v_ready(v_ready), .cpu_active(cpu_active), .vcode(vcode), .clk_sel(clk_sel)
  );

  // Monitor: pops expected read data in the access phase
  always @(negedge pclk) begin
    if (psel && penable && !pwrite) begin
      if (sb.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard empty act=%h exp=none", prdata);
      end else begin
        sb_item_t it;
        it = sb.pop_front();
        n_cmp++;
        if (prdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s act=%h exp=%h", it.tag, prdata, it.exp);
        end
      end
    end
  end

  task automatic apb_wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge pclk); #1;
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge pclk); #1;
    penable = 1;
    @(posedge pclk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic chk_read(input logic [4:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(posedge pclk); #1;
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(posedge pclk); #1;
    penable = 1;
    @(posedge pclk); #1;
    psel = 0; penable = 0;
  endtask

  task automatic chk_pin(input string tag, input logic [31:0] act, input logic [31:0] e);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, e);
    end
  endtask

  task automatic pulse_ready();
    @(posedge pclk); #1; v_ready = 1;
    @(posedge pclk); #1; v_ready = 0;
  endtask

  function automatic logic [31:0] stat(input bit b, input int cur, input int tgt);
    return {21'd0, 3'(tgt), 1'b0, 3'(cur), 3'd0, b};
  endfunction

  initial begin
    repeat (100000) @(posedge pclk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    presetn = 0;
    repeat (3) @(posedge pclk);
    @(negedge pclk); presetn = 1;

    // R1 reset state
    chk_pin("R1 vcode", 32'(vcode), 32'd4);
    chk_pin("R1 clk_sel", 32'(clk_sel), 32'd0);
    chk_read(5'h08, stat(0, 0, 0), "R1 status");
    chk_read(5'h04, 32'd100, "R1 cap");

    // R5 raise to 50% -> index 4, voltage first
    apb_wr(5'h00, 32'd50);
    repeat (3) @(posedge pclk); #1;
    chk_pin("R5 vcode raised", 32'(vcode), 32'd8);
    chk_pin("R5 clk held", 32'(clk_sel), 32'd0);
    chk_read(5'h08, stat(1, 0, 4), "R8 status busy");
    chk_read(5'h00, 32'd50, "R2 req readback");
    chk_pin("R5 clk still held", 32'(clk_sel), 32'd0);
    pulse_ready();
    chk_pin("R5 clk after ready", 32'(clk_sel), 32'd4);
    chk_read(5'h08, stat(0, 4, 4), "R8 status settled");

    // R6 drop to 20% -> index 1, clock first, no ready
    apb_wr(5'h00, 32'd20);
    @(posedge pclk); #1;
    chk_pin("R6 clk first", 32'(clk_sel), 32'd1);
    chk_pin("R6 volt not yet", 32'(vcode), 32'd8);
    @(posedge pclk); #1;
    chk_pin("R6 volt follows", 32'(vcode), 32'd5);
    chk_read(5'h08, stat(0, 1, 1), "R6 status");

    // R3 threshold edges
    apb_wr(5'h00, 32'd12);
    repeat (3) @(posedge pclk);
    chk_read(5'h08, stat(0, 1, 1), "R3 req 12 idx1");
    apb_wr(5'h00, 32'd11);
    repeat (3) @(posedge pclk); #1;
    chk_read(5'h08, stat(0, 0, 0), "R3 req 11 idx0");
    chk_pin("R3 vcode idx0", 32'(vcode), 32'd4);
    apb_wr(5'h00, 32'd120);
    repeat (2) @(posedge pclk);
    chk_read(5'h08, stat(1, 0, 7), "R3 req 120 clamps to idx7");
    pulse_ready();
    chk_pin("R3 clk idx7", 32'(clk_sel), 32'd7);
    chk_pin("R3 vcode idx7", 32'(vcode), 32'd11);

    // R4 cap 40 -> index 3
    apb_wr(5'h04, 32'd40);
    repeat (3) @(posedge pclk); #1;
    chk_pin("R4 clk capped", 32'(clk_sel), 32'd3);
    chk_read(5'h08, stat(0, 3, 3), "R4 status capped");
    chk_read(5'h04, 32'd40, "R2 cap readback");

    // R7 request during a raise
    apb_wr(5'h04, 32'd100);
    repeat (2) @(posedge pclk); #1;
    chk_pin("R7 raising vcode", 32'(vcode), 32'd11);
    apb_wr(5'h00, 32'd50);
    chk_read(5'h08, stat(1, 3, 4), "R7 pending target");
    chk_pin("R7 clk held", 32'(clk_sel), 32'd3);
    pulse_ready();
    chk_pin("R7 finished first raise", 32'(clk_sel), 32'd7);
    repeat (2) @(posedge pclk); #1;
    chk_pin("R7 then lowered clk", 32'(clk_sel), 32'd4);
    chk_pin("R7 then lowered vcode", 32'(vcode), 32'd8);
    chk_read(5'h08, stat(0, 4, 4), "R7 settled");

    // R9 load counters
    apb_wr(5'h0C, 32'd0);
    cpu_active = 1;
    repeat (5) @(posedge pclk); #1;
    cpu_active = 0;
    repeat (5) @(posedge pclk);
    chk_read(5'h0C, 32'd12, "R9 total cycles");
    chk_read(5'h10, 32'd5, "R9 active cycles");

    repeat (2) @(posedge pclk);
    if (sb.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard left act=%0d exp=0", sb.size());
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule